// File: doc/BRIEF.md
# Diagnostic Beep Code Sequencer

This block turns an error code into a pattern of short beeps on a speaker. The code is cut into equal fields. The most significant field is played first. Each field sounds as a burst that holds one beep more than the field's value, so a zero field still gives one beep. Beeps inside a burst are separated by a short space. Bursts are separated by a longer gap.

A start strobe latches the code and a play mode. In one-shot mode the pattern plays once, then a done pulse fires. In terminal mode the pattern repeats after a long pause until reset. A separate request sounds one lone short beep, as a go-ahead signal that does not involve the code path.

All durations are whole multiples of a prescaler unit, counted in clock cycles. While a beep is active, the speaker line carries a gated square wave. At all other times it is held low.

Top module: `beep_seq`

## Requirements
- R1: After reset, busy_o, done_o, beep_o and spk_o are all low.
- R2: When the block is idle, start_i latches code_i and terminal_i. In the next cycle busy_o and beep_o are both high, so the first beep begins at once.
- R3: The code is played in fields of GRP_W bits, starting with bits [CODE_W-1 -: GRP_W]. A field of value v gives v+1 beeps. With 2-bit fields, value 0 gives 1 beep and value 3 gives 4 beeps. Code 16h plays 1, 2, 2, 3 beeps.
- R4: Each beep lasts ON_UNITS*UNIT_CYC cycles. The space between beeps of one burst lasts SPACE_UNITS*UNIT_CYC cycles. The gap between bursts lasts GROUP_UNITS*UNIT_CYC cycles.
- R5: In one-shot mode (terminal_i=0 at start), done_o is high for exactly one cycle. That cycle is the one in which busy_o and beep_o fall at the end of the last beep.
- R6: In terminal mode (terminal_i=1 at start), the last beep is followed by a silence of PAUSE_UNITS*UNIT_CYC cycles. The whole pattern then restarts from the first field. This repeats until reset, and done_o never fires.
- R7: A start_i pulse while busy_o is high is ignored. The pattern, the latched code and the latched mode are unchanged.
- R8: ready_i in idle sounds one beep of ON_UNITS*UNIT_CYC cycles. busy_o is high during that beep and done_o stays low. ready_i while busy is ignored. If start_i and ready_i arrive together, start_i wins.
- R9: While beep_o is high, spk_o is a square wave with a half period of TONE_DIV cycles that starts high on the first cycle of each beep. spk_o is low whenever beep_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, one cycle |
| code_i | input | CODE_W | Error code to play |
| terminal_i | input | 1 | Repeat mode, sampled on an accepted start |
| ready_i | input | 1 | Request for one lone beep |
| busy_o | output | 1 | High while a pattern or lone beep plays |
| done_o | output | 1 | One-cycle pulse at the end of a one-shot pattern |
| beep_o | output | 1 | Beep envelope |
| spk_o | output | 1 | Gated square wave for the speaker |

## Verification
The hardest cases to reach are the ones where a second request lands while a pattern is in flight. These are a start with a different code and terminal mode set, a lone-beep request, and a start and a lone-beep request in the same cycle. The stimulus fires these requests partway through a burst. It then checks that the measured beep and silence run lengths match only the first pattern. It also checks that the block goes idle, with one done pulse, instead of looping. Terminal mode is driven through two full rounds, including the pause, before a reset cuts it off.

// File: rtl/beep_pkg.sv
package beep_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ON,
      ST_SPACE,
      ST_GAP,
      ST_PAUSE,
      ST_SOLO
   } beep_st_t;
endpackage

// File: rtl/beep_timer.sv
// Loadable down counter: a load of N-1 makes the current state last N cycles.
module beep_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] load_val_i,
   output logic          expired_o
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= load_val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - TW'(1);
   end

   assign expired_o = (cnt_q == '0);

   // R4: durations rely on a strict one-per-cycle countdown
   p_countdown_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - TW'(1)));
endmodule

// File: rtl/beep_grp_sel.sv
// Picks one field of the code; field 0 is the most significant one.
module beep_grp_sel #(
   parameter int CODE_W = 8,
   parameter int GRP_W  = 2,
   parameter int IW     = 2
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic [IW-1:0]     idx_i,
   output logic [GRP_W-1:0]  grp_o
);
   localparam int NGRP = CODE_W / GRP_W;

   logic [GRP_W-1:0] grp_a [NGRP];

   for (genvar g = 0; g < NGRP; g++) begin : g_slice
      assign grp_a[g] = code_i[CODE_W-1-g*GRP_W -: GRP_W];
   end

   always_comb begin
      grp_o = grp_a[0];
      for (int i = 0; i < NGRP; i++) begin
         if (IW'(i) == idx_i) grp_o = grp_a[i];
      end
   end
endmodule

// File: rtl/beep_tone.sv
// Square-wave gate for the speaker; TONE_EN=0 gives a plain enable level.
module beep_tone #(
   parameter int TONE_DIV = 4,
   parameter bit TONE_EN  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic beep_i,
   output logic spk_o
);
   if (TONE_EN) begin : g_square
      localparam int DW = (TONE_DIV > 1) ? $clog2(TONE_DIV) : 1;
      logic [DW-1:0] div_q;
      logic          phase_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            div_q   <= '0;
            phase_q <= 1'b1;
         end else if (!beep_i) begin
            div_q   <= '0;
            phase_q <= 1'b1;
         end else if (div_q == DW'(TONE_DIV-1)) begin
            div_q   <= '0;
            phase_q <= ~phase_q;
         end else begin
            div_q   <= div_q + DW'(1);
         end
      end

      assign spk_o = beep_i & phase_q;
   end else begin : g_level
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign spk_o      = beep_i;
   end

   // R9: speaker silent outside a beep
   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !beep_i |-> !spk_o);
endmodule

// File: rtl/beep_seq.sv
module beep_seq
   import beep_pkg::*;
#(
   parameter int          CODE_W      = 8,
   parameter int          GRP_W       = 2,
   parameter int unsigned UNIT_CYC    = 50000,
   parameter int unsigned ON_UNITS    = 150,
   parameter int unsigned SPACE_UNITS = 150,
   parameter int unsigned GROUP_UNITS = 450,
   parameter int unsigned PAUSE_UNITS = 1500,
   parameter int          TONE_DIV    = 25000,
   parameter bit          TONE_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              terminal_i,
   input  logic              ready_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              beep_o,
   output logic              spk_o
);
   localparam int          NGRP    = CODE_W / GRP_W;
   localparam int          IW      = (NGRP > 1) ? $clog2(NGRP) : 1;
   localparam int          LW      = GRP_W + 1;
   localparam int unsigned ON_CYC  = UNIT_CYC * ON_UNITS;
   localparam int unsigned SP_CYC  = UNIT_CYC * SPACE_UNITS;
   localparam int unsigned GP_CYC  = UNIT_CYC * GROUP_UNITS;
   localparam int unsigned PS_CYC  = UNIT_CYC * PAUSE_UNITS;
   localparam int unsigned MAX_A   = (ON_CYC > SP_CYC) ? ON_CYC : SP_CYC;
   localparam int unsigned MAX_B   = (GP_CYC > PS_CYC) ? GP_CYC : PS_CYC;
   localparam int unsigned MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int          TW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

   if (GRP_W < 1 || CODE_W % GRP_W != 0) begin : g_chk_split
      $error("CODE_W must be a whole multiple of GRP_W");
   end
   if (UNIT_CYC < 1 || ON_UNITS < 1 || SPACE_UNITS < 1 ||
       GROUP_UNITS < 1 || PAUSE_UNITS < 1) begin : g_chk_time
      $error("all durations must be at least one cycle");
   end
   if (TONE_DIV < 1) begin : g_chk_tone
      $error("TONE_DIV must be at least 1");
   end

   beep_st_t          st_q, st_d;
   logic [CODE_W-1:0] code_q, code_d;
   logic              term_q, term_d;
   logic [IW-1:0]     idx_q, idx_d, idx_nxt;
   logic [LW-1:0]     left_q, left_d;
   logic              done_q, done_d;
   logic              ld;
   logic [TW-1:0]     ld_val;
   logic              expired;
   logic [GRP_W-1:0]  grp_nxt;
   logic [GRP_W-1:0]  grp_new;

   assign idx_nxt = (idx_q == IW'(NGRP-1)) ? '0 : idx_q + IW'(1);
   assign grp_new = code_i[CODE_W-1 -: GRP_W];

   beep_grp_sel #(.CODE_W(CODE_W), .GRP_W(GRP_W), .IW(IW)) u_sel (
      .code_i (code_q),
      .idx_i  (idx_nxt),
      .grp_o  (grp_nxt)
   );

   beep_timer #(.TW(TW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (ld),
      .load_val_i (ld_val),
      .expired_o  (expired)
   );

   always_comb begin
      st_d   = st_q;
      code_d = code_q;
      term_d = term_q;
      idx_d  = idx_q;
      left_d = left_q;
      done_d = 1'b0;
      ld     = 1'b0;
      ld_val = TW'(ON_CYC - 1);
      unique case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               code_d = code_i;
               term_d = terminal_i;
               idx_d  = '0;
               left_d = {1'b0, grp_new} + LW'(1);
               st_d   = ST_ON;
               ld     = 1'b1;
            end else if (ready_i) begin
               st_d = ST_SOLO;
               ld   = 1'b1;
            end
         end
         ST_ON: begin
            if (expired) begin
               if (left_q > LW'(1)) begin
                  left_d = left_q - LW'(1);
                  st_d   = ST_SPACE;
                  ld     = 1'b1;
                  ld_val = TW'(SP_CYC - 1);
               end else if (idx_q != IW'(NGRP-1)) begin
                  st_d   = ST_GAP;
                  ld     = 1'b1;
                  ld_val = TW'(GP_CYC - 1);
               end else if (term_q) begin
                  st_d   = ST_PAUSE;
                  ld     = 1'b1;
                  ld_val = TW'(PS_CYC - 1);
               end else begin
                  st_d   = ST_IDLE;
                  done_d = 1'b1;
               end
            end
         end
         ST_SPACE: begin
            if (expired) begin
               st_d = ST_ON;
               ld   = 1'b1;
            end
         end
         ST_GAP, ST_PAUSE: begin
            if (expired) begin
               idx_d  = idx_nxt;
               left_d = {1'b0, grp_nxt} + LW'(1);
               st_d   = ST_ON;
               ld     = 1'b1;
            end
         end
         ST_SOLO: begin
            if (expired) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         code_q <= '0;
         term_q <= 1'b0;
         idx_q  <= '0;
         left_q <= '0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         code_q <= code_d;
         term_q <= term_d;
         idx_q  <= idx_d;
         left_q <= left_d;
         done_q <= done_d;
      end
   end

   assign busy_o = (st_q != ST_IDLE);
   assign beep_o = (st_q == ST_ON) || (st_q == ST_SOLO);
   assign done_o = done_q;

   beep_tone #(.TONE_DIV(TONE_DIV), .TONE_EN(TONE_EN)) u_tone (
      .clk    (clk),
      .rst_n  (rst_n),
      .beep_i (beep_o),
      .spk_o  (spk_o)
   );

   // R2: an accepted start begins sounding in the next cycle
   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && start_i) |=> (busy_o && beep_o));

   // R7: a start during play leaves the latched code alone
   p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(code_q));

   // R5: done marks the fall of busy
   p_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   // R3: burst count stays within one to 2**GRP_W beeps
   p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ON) |-> (left_q != '0 && left_q <= LW'(1 << GRP_W)));

   // R8: a lone beep never produces a done pulse
   p_solo_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SOLO) |=> !done_o);
endmodule

// File: tb/tb_beep_seq.sv
module tb_beep_seq;
   localparam int U   = 4;
   localparam int ONU = 2;
   localparam int SPU = 2;
   localparam int GPU = 6;
   localparam int PSU = 10;
   localparam int TD  = 2;
   localparam int ON_L = U * ONU;
   localparam int SP_L = U * SPU;
   localparam int GP_L = U * GPU;
   localparam int PS_L = U * PSU;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] code_i = 8'h00;
   logic       terminal_i = 1'b0;
   logic       ready_i = 1'b0;
   logic       busy_o, done_o, beep_o, spk_o;

   always #10 clk = ~clk;

   beep_seq #(
      .CODE_W(8), .GRP_W(2), .UNIT_CYC(U), .ON_UNITS(ONU),
      .SPACE_UNITS(SPU), .GROUP_UNITS(GPU), .PAUSE_UNITS(PSU),
      .TONE_DIV(TD), .TONE_EN(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .code_i(code_i),
      .terminal_i(terminal_i), .ready_i(ready_i), .busy_o(busy_o),
      .done_o(done_o), .beep_o(beep_o), .spk_o(spk_o)
   );

   typedef struct packed {
      logic        lvl;
      logic [31:0] len;
   } run_t;

   run_t exp_q[$];
   int   total = 0;
   int   bad = 0;
   int   done_seen = 0;
   int   on_runs = 0;

   task automatic chk(bit ok, string req, string what, int act, int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic push(logic l, int n);
      run_t r;
      r.lvl = l;
      r.len = n;
      exp_q.push_back(r);
   endtask

   // Driver side of the scoreboard: expected run lengths from R3, R4, R6
   task automatic play(logic [7:0] c, bit term, int rounds);
      for (int r = 0; r < rounds; r++) begin
         for (int g = 0; g < 4; g++) begin
            int n;
            n = int'(c[7-2*g -: 2]) + 1;
            for (int b = 0; b < n; b++) begin
               push(1'b1, ON_L);
               if (b < n - 1) push(1'b0, SP_L);
            end
            if (g < 3) push(1'b0, GP_L);
         end
         if (term) push(1'b0, PS_L);
      end
   endtask

   task automatic pulse_start(logic [7:0] c, logic t, logic rdy);
      @(negedge clk);
      code_i = c; terminal_i = t; start_i = 1'b1; ready_i = rdy;
      @(negedge clk);
      start_i = 1'b0; ready_i = 1'b0;
   endtask

   task automatic pulse_ready();
      @(negedge clk);
      ready_i = 1'b1;
      @(negedge clk);
      ready_i = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy_o) @(negedge clk);
      @(negedge clk);
   endtask

   // Monitor side: measure envelope runs and compare against the queue
   logic lvl = 1'b0;
   int   run = 0;
   bit   run_valid = 1'b0;
   bit   tone_ok = 1'b1;
   logic prev_busy = 1'b0;

   always @(negedge clk) begin
      if (!rst_n) begin
         lvl = 1'b0; run = 0; run_valid = 1'b0; tone_ok = 1'b1; prev_busy = 1'b0;
      end else begin
         if (beep_o !== lvl) begin
            if (run_valid) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R3", "unexpected run", run, 0);
               end else begin
                  run_t e;
                  e = exp_q.pop_front();
                  chk(e.lvl == lvl && e.len == run, "R3 R4",
                      lvl ? "beep length" : "silence length", run, int'(e.len));
               end
            end
            chk(tone_ok, "R9", "speaker pattern over run", int'(tone_ok), 1);
            if (lvl) on_runs++;
            lvl = beep_o; run = 1; run_valid = busy_o; tone_ok = 1'b1;
         end else begin
            run++;
            if (!busy_o) run_valid = 1'b0;
         end
         if (spk_o !== (lvl ? (((run - 1) / TD) % 2 == 0) : 1'b0)) tone_ok = 1'b0;
         if (done_o) begin
            done_seen++;
            chk(prev_busy && !busy_o, "R5", "done at busy fall", int'(busy_o), 0);
         end
         prev_busy = busy_o;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic one_shot(logic [7:0] c, int beeps);
      int r0, d0;
      r0 = on_runs; d0 = done_seen;
      play(c, 1'b0, 1);
      pulse_start(c, 1'b0, 1'b0);
      chk(busy_o && beep_o, "R2", "busy and beep after start", int'({busy_o, beep_o}), 3);
      wait_idle();
      chk(exp_q.size() == 0, "R3", "runs left in queue", exp_q.size(), 0);
      chk(on_runs - r0 == beeps, "R3", "beep total", on_runs - r0, beeps);
      chk(done_seen - d0 == 1, "R5", "done pulses", done_seen - d0, 1);
   endtask

   initial begin
      int r0, d0;
      repeat (5) @(negedge clk);
      // R1: reset state
      chk(!busy_o, "R1", "busy in reset", int'(busy_o), 0);
      chk(!done_o, "R1", "done in reset", int'(done_o), 0);
      chk(!beep_o, "R1", "beep in reset", int'(beep_o), 0);
      chk(!spk_o,  "R1", "spk in reset",  int'(spk_o), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R3: 16h plays 1-2-2-3
      one_shot(8'h16, 8);
      // R3: all-zero fields give single beeps, all-ones give four
      one_shot(8'h00, 4);
      one_shot(8'hFF, 16);
      one_shot(8'hB4, 10);

      // R7: start and lone-beep requests during play are ignored
      r0 = on_runs; d0 = done_seen;
      play(8'h21, 1'b0, 1);
      pulse_start(8'h21, 1'b0, 1'b0);
      repeat (20) @(negedge clk);
      pulse_start(8'hFF, 1'b1, 1'b0);
      repeat (5) @(negedge clk);
      pulse_ready();
      wait_idle();
      repeat (10) @(negedge clk);
      chk(!busy_o, "R7", "idle after first pattern", int'(busy_o), 0);
      chk(exp_q.size() == 0, "R7", "runs left in queue", exp_q.size(), 0);
      chk(on_runs - r0 == 7, "R7", "beep total", on_runs - r0, 7);
      chk(done_seen - d0 == 1, "R7", "done pulses", done_seen - d0, 1);

      // R8: lone beep from idle
      r0 = on_runs; d0 = done_seen;
      push(1'b1, ON_L);
      pulse_ready();
      chk(busy_o && beep_o, "R8", "lone beep active", int'({busy_o, beep_o}), 3);
      wait_idle();
      chk(exp_q.size() == 0, "R8", "lone beep runs left", exp_q.size(), 0);
      chk(on_runs - r0 == 1, "R8", "lone beep count", on_runs - r0, 1);
      chk(done_seen == d0, "R8", "done on lone beep", done_seen - d0, 0);

      // R8: start beats ready in the same cycle
      r0 = on_runs;
      play(8'h40, 1'b0, 1);
      pulse_start(8'h40, 1'b0, 1'b1);
      wait_idle();
      chk(exp_q.size() == 0, "R8", "start wins runs left", exp_q.size(), 0);
      chk(on_runs - r0 == 5, "R8", "start wins beep total", on_runs - r0, 5);

      // R6: terminal mode repeats with a pause and no done
      d0 = done_seen;
      play(8'h9C, 1'b1, 2);
      pulse_start(8'h9C, 1'b1, 1'b0);
      while (exp_q.size() > 0) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(busy_o && beep_o, "R6", "third round sounding", int'({busy_o, beep_o}), 3);
      chk(done_seen == d0, "R6", "done in terminal mode", done_seen - d0, 0);
      rst_n = 1'b0;
      exp_q.delete();
      repeat (2) @(negedge clk);
      chk(!busy_o && !spk_o, "R1", "reset stops terminal loop", int'({busy_o, spk_o}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule